// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block carries out one string operation over memory, either once or repeated under a count, and drives a small synchronous memory port while doing so. The five operations are block move, memory-to-memory compare, store of the accumulator, load into the accumulator, and scan of memory against the accumulator. Elements are 1, 2 or 4 bytes wide. A direction input chooses whether the index registers count up or down.

A caller loads the operation, element size, direction, repeat mode, the two index values, the count and the accumulator with a one-cycle start pulse. The block then steps through the elements. When it has finished it raises done for one cycle, and the updated index, count, accumulator and zero-flag values are held on the outputs. A start that arrives while the block is busy is ignored.

The memory port has no back-pressure. A read strobe returns its data on the read-data input one cycle later. A write completes in the cycle its strobe is high. The element always sits in the low bytes of the data buses, so byte-enable bit k covers the byte at address+k. Because the port has no handshake, the memory must accept one access every cycle.

Top module: `strseq_top`

## Requirements
- R1: After reset, the index, count, accumulator and zero-flag outputs are 0, and done, busy and both memory strobes are low.
- R2: After each element, an index register that the operation uses changes by the element size in bytes (size code 0 = 1, 1 = 2, 2 = 4). It increases when dir_i is 0 and decreases when dir_i is 1.
- R3: A move (op code 0) writes the source-indexed element to the destination index and steps both indexes.
- R4: A compare (op code 1) reads the source element and then the destination element. It sets zf_o to 1 when the two are equal within the element size and to 0 otherwise. It writes nothing and steps both indexes.
- R5: A scan (op code 4) compares the low element-size bytes of the accumulator with the destination element, sets zf_o the same way as a compare, and steps only the destination index.
- R6: A store (op code 2) writes the low bytes of the accumulator to the destination index and steps only that index. A load (op code 3) replaces the low element-size bytes of the accumulator with the source element, keeps the upper bytes, and steps only the source index. Move, store and load leave zf_o unchanged.
- R7: With repeat mode 0 (none), exactly one element is processed and the count is left unchanged.
- R8: With repeat mode 1 (repeat), the count is decremented after each element and the operation stops when the count reaches zero.
- R9: Repeat mode 2 also stops a compare or scan after an element that leaves zf_o at 0. Repeat mode 3 also stops a compare or scan after an element that leaves zf_o at 1. The count test is made first. For move, store and load, modes 2 and 3 behave like mode 1.
- R10: A repeated operation (mode not 0) that starts with a count of 0 makes no memory access, raises done in the cycle after start, and leaves all outputs at the values loaded from the inputs (zf_o unchanged).
- R11: Read and write strobes are never high together. mem_be_o is 4'b0001, 4'b0011 or 4'b1111 for size codes 0, 1 and 2. Read data is taken one cycle after the read strobe. Write data carries the element in its low bytes.
- R12: done_o is a single-cycle pulse, busy_o is low while done_o is high, and a start while busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; the inputs below are sampled when it is high and the block is idle |
| op_i | input | 3 | Operation: 0 move, 1 compare, 2 store, 3 load, 4 scan |
| esize_i | input | 2 | Element size code: 0 byte, 1 two bytes, 2 four bytes |
| dir_i | input | 1 | 0 count the indexes up, 1 count them down |
| rep_i | input | 2 | Repeat mode: 0 none, 1 repeat, 2 repeat while zero flag set, 3 repeat while clear |
| src_i | input | AW | Initial source index |
| dst_i | input | AW | Initial destination index |
| cnt_i | input | CW | Initial count |
| acc_i | input | 32 | Initial accumulator |
| src_o | output | AW | Current source index |
| dst_o | output | AW | Current destination index |
| cnt_o | output | CW | Current count |
| acc_o | output | 32 | Current accumulator |
| zf_o | output | 1 | Zero flag from the latest compare or scan element |
| done_o | output | 1 | One-cycle pulse when the operation ends |
| busy_o | output | 1 | High while an operation is in progress |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_addr_o | output | AW | Byte address of the element |
| mem_be_o | output | 4 | Byte enables, bit k for address+k |
| mem_wdata_o | output | 32 | Write data, element in the low bytes |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read strobe |

## Verification
The hardest situation to reach is an early stop under the two zero-flag repeat modes. The stop has to land on a chosen element while the count is still nonzero, and it has to land there for either direction and every element size. For each run the bench fills memory with a pattern in which the source and destination regions never agree. It then plants equal elements at computed positions: either a run of matches at the front, or a single match at one element. Under mode 2 this ends the operation on the first mismatch, and under mode 3 on the first match. A bench model replays the same memory image to predict the final indexes, count and flag. The final memory contents are compared byte for byte with the model.

// File: rtl/strseq_pkg.sv
package strseq_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_STORE = 3'd2,
    OP_LOAD  = 3'd3,
    OP_SCAN  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RP_NONE     = 2'd0,
    RP_ALL      = 2'd1,
    RP_WHILE_EQ = 2'd2,
    RP_WHILE_NE = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RDA, S_RDB, S_EXE, S_WR
  } state_e;

  function automatic logic [2:0] elem_bytes(input logic [1:0] esz);
    case (esz)
      2'd0:    elem_bytes = 3'd1;
      2'd1:    elem_bytes = 3'd2;
      default: elem_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] elem_mask(input logic [1:0] esz);
    case (esz)
      2'd0:    elem_mask = DATA_W'(32'h0000_00FF);
      2'd1:    elem_mask = DATA_W'(32'h0000_FFFF);
      default: elem_mask = '1;
    endcase
  endfunction

  function automatic logic [BE_W-1:0] elem_be(input logic [1:0] esz);
    case (esz)
      2'd0:    elem_be = BE_W'(4'b0001);
      2'd1:    elem_be = BE_W'(4'b0011);
      default: elem_be = '1;
    endcase
  endfunction

  function automatic logic uses_src(input op_e op);
    uses_src = (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD);
  endfunction

  function automatic logic uses_dst(input op_e op);
    uses_dst = (op == OP_MOVE) || (op == OP_CMP) || (op == OP_STORE) || (op == OP_SCAN);
  endfunction

  function automatic logic sets_flag(input op_e op);
    sets_flag = (op == OP_CMP) || (op == OP_SCAN);
  endfunction

  function automatic state_e first_state(input op_e op);
    case (op)
      OP_MOVE, OP_CMP, OP_LOAD: first_state = S_RDA;
      OP_SCAN:                  first_state = S_RDB;
      OP_STORE:                 first_state = S_WR;
      default:                  first_state = S_EXE;
    endcase
  endfunction
endpackage

// File: rtl/strseq_step.sv
module strseq_step import strseq_pkg::*; #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx_i,
  input  logic [1:0]    esz_i,
  input  logic          dir_i,
  input  logic          en_i,
  output logic [AW-1:0] idx_o
);
  logic [AW-1:0] amt;
  assign amt = AW'(elem_bytes(esz_i));

  always_comb begin
    if (!en_i)      idx_o = idx_i;
    else if (dir_i) idx_o = idx_i - amt;
    else            idx_o = idx_i + amt;
  end
endmodule

// File: rtl/strseq_eval.sv
module strseq_eval import strseq_pkg::*; (
  input  op_e               op_i,
  input  logic [1:0]        esz_i,
  input  logic [DATA_W-1:0] first_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              zf_i,
  output logic              zf_o,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] elem;
  assign mask = elem_mask(esz_i);
  assign elem = rdata_i & mask;

  always_comb begin
    case (op_i)
      OP_CMP:  zf_o = ((first_i & mask) == elem);
      OP_SCAN: zf_o = ((acc_i & mask) == elem);
      default: zf_o = zf_i;
    endcase
    acc_o = (op_i == OP_LOAD) ? ((acc_i & ~mask) | elem) : acc_i;
  end
endmodule

// File: rtl/strseq_term.sv
module strseq_term import strseq_pkg::*; #(
  parameter int CW = 16
) (
  input  rep_e          rep_i,
  input  op_e           op_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          zf_i,
  output logic [CW-1:0] cnt_o,
  output logic          stop_o
);
  logic flag_stop;

  always_comb begin
    cnt_o = (rep_i == RP_NONE) ? cnt_i : cnt_i - CW'(1);
    flag_stop = sets_flag(op_i) &&
                (((rep_i == RP_WHILE_EQ) && !zf_i) || ((rep_i == RP_WHILE_NE) && zf_i));
    stop_o = (rep_i == RP_NONE) || (cnt_o == '0) || flag_stop;
  end
endmodule

// File: rtl/strseq_top.sv
module strseq_top import strseq_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        esize_i,
  input  logic              dir_i,
  input  logic [1:0]        rep_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [CW-1:0]     cnt_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zf_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int NIDX = 2;

  state_e            st;
  op_e               op_q;
  rep_e              rep_q;
  logic [1:0]        esz_q;
  logic              dir_q;
  logic [AW-1:0]     src_q, dst_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] acc_q, first_q;
  logic              zf_q, done_q;

  logic              last;
  logic              zf_nx, stop;
  logic [DATA_W-1:0] acc_nx;
  logic [CW-1:0]     cnt_nx;
  logic [AW-1:0]     idx_cur [NIDX];
  logic [AW-1:0]     idx_nxt [NIDX];
  logic              idx_en  [NIDX];

  assign last       = (st == S_EXE) || (st == S_WR);
  assign idx_cur[0] = src_q;
  assign idx_cur[1] = dst_q;
  assign idx_en[0]  = last && uses_src(op_q);
  assign idx_en[1]  = last && uses_dst(op_q);

  for (genvar g = 0; g < NIDX; g++) begin : g_idx
    strseq_step #(.AW(AW)) u_step (
      .idx_i (idx_cur[g]),
      .esz_i (esz_q),
      .dir_i (dir_q),
      .en_i  (idx_en[g]),
      .idx_o (idx_nxt[g])
    );
  end

  strseq_eval u_eval (
    .op_i    (op_q),
    .esz_i   (esz_q),
    .first_i (first_q),
    .rdata_i (mem_rdata_i),
    .acc_i   (acc_q),
    .zf_i    (zf_q),
    .zf_o    (zf_nx),
    .acc_o   (acc_nx)
  );

  strseq_term #(.CW(CW)) u_term (
    .rep_i  (rep_q),
    .op_i   (op_q),
    .cnt_i  (cnt_q),
    .zf_i   (zf_nx),
    .cnt_o  (cnt_nx),
    .stop_o (stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_MOVE;
      rep_q   <= RP_NONE;
      esz_q   <= '0;
      dir_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      first_q <= '0;
      zf_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            op_q  <= op_e'(op_i);
            rep_q <= rep_e'(rep_i);
            esz_q <= esize_i;
            dir_q <= dir_i;
            src_q <= src_i;
            dst_q <= dst_i;
            cnt_q <= cnt_i;
            acc_q <= acc_i;
            if ((rep_e'(rep_i) != RP_NONE) && (cnt_i == '0)) done_q <= 1'b1;
            else st <= first_state(op_e'(op_i));
          end
        end
        S_RDA: begin
          if (op_q == OP_CMP)       st <= S_RDB;
          else if (op_q == OP_MOVE) st <= S_WR;
          else                      st <= S_EXE;
        end
        S_RDB: begin
          first_q <= mem_rdata_i;
          st      <= S_EXE;
        end
        S_EXE, S_WR: begin
          src_q <= idx_nxt[0];
          dst_q <= idx_nxt[1];
          cnt_q <= cnt_nx;
          acc_q <= acc_nx;
          zf_q  <= zf_nx;
          if (stop) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= first_state(op_q);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_o    = (st == S_RDA) || (st == S_RDB);
  assign mem_wr_o    = (st == S_WR);
  assign mem_addr_o  = (st == S_RDA) ? src_q : dst_q;
  assign mem_be_o    = elem_be(esz_q);
  assign mem_wdata_o = ((op_q == OP_MOVE) ? mem_rdata_i : acc_q) & elem_mask(esz_q);

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign acc_o  = acc_q;
  assign zf_o   = zf_q;
  assign done_o = done_q;
  assign busy_o = (st != S_IDLE);

  assert_rw_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  assert_be_size_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> ($countones(mem_be_o) == int'(elem_bytes(esz_q))));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd_o && !mem_wr_o));

  assert_cnt_nonincr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (cnt_o <= $past(cnt_o)));
endmodule

// File: tb/strseq_top_tb.sv
module strseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  esize_i = '0;
  logic        dir_i = 1'b0;
  logic [1:0]  rep_i = '0;
  logic [31:0] src_i = '0, dst_i = '0, acc_i = '0;
  logic [15:0] cnt_i = '0;
  logic [31:0] src_o, dst_o, acc_o;
  logic [15:0] cnt_o;
  logic        zf_o, done_o, busy_o, mem_rd_o, mem_wr_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic [3:0]  mem_be_o;

  logic [7:0]  mem     [256];
  logic [7:0]  ld_mem  [256];
  logic [7:0]  exp_mem [256];
  logic        ld_en = 1'b0;
  int          strobes = 0;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;
  logic        e_zf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strseq_top #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .esize_i(esize_i),
    .dir_i(dir_i), .rep_i(rep_i), .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i),
    .acc_i(acc_i), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .acc_o(acc_o),
    .zf_o(zf_o), .done_o(done_o), .busy_o(busy_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk) begin
    if (ld_en) begin
      for (int i = 0; i < 256; i++) mem[i] <= ld_mem[i];
    end else begin
      if (mem_wr_o)
        for (int k = 0; k < 4; k++)
          if (mem_be_o[k]) mem[mem_addr_o[7:0] + 8'(k)] <= mem_wdata_o[8*k +: 8];
      if (mem_rd_o)
        for (int k = 0; k < 4; k++)
          mem_rdata_i[8*k +: 8] <= mem[mem_addr_o[7:0] + 8'(k)];
      if (mem_rd_o || mem_wr_o) strobes <= strobes + 1;
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] erd(input logic [31:0] ad, input int n);
    logic [31:0] r = '0;
    for (int b = 0; b < n; b++) r[8*b +: 8] = exp_mem[ad[7:0] + 8'(b)];
    return r;
  endfunction

  task automatic ewr(input logic [31:0] ad, input logic [31:0] v, input int n);
    for (int b = 0; b < n; b++) exp_mem[ad[7:0] + 8'(b)] = v[8*b +: 8];
  endtask

  task automatic model(input int op, input int esz, input int dir, input int rep,
                       inout logic [31:0] s, inout logic [31:0] d, inout logic [15:0] c,
                       inout logic [31:0] a, inout logic z, output int nacc);
    int n;
    logic [31:0] m;
    n = 1 << esz;
    m = (esz == 0) ? 32'hFF : (esz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    nacc = 0;
    if (rep != 0 && c == 0) return;
    while (1) begin
      case (op)
        0: begin ewr(d, erd(s, n), n); nacc += 2; end
        1: begin z = (erd(s, n) == erd(d, n)); nacc += 2; end
        2: begin ewr(d, a & m, n); nacc += 1; end
        3: begin a = (a & ~m) | erd(s, n); nacc += 1; end
        default: begin z = ((a & m) == erd(d, n)); nacc += 1; end
      endcase
      if (op == 0 || op == 1 || op == 3) s = dir ? s - 32'(n) : s + 32'(n);
      if (op != 3) d = dir ? d - 32'(n) : d + 32'(n);
      if (rep == 0) break;
      c = c - 16'd1;
      if (c == 0) break;
      if ((op == 1 || op == 4) && rep == 2 && !z) break;
      if ((op == 1 || op == 4) && rep == 3 && z) break;
    end
  endtask

  task automatic load_mem();
    for (int i = 0; i < 256; i++) exp_mem[i] = ld_mem[i];
    @(negedge clk); ld_en = 1'b1;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic run(input int op, input int esz, input int dir, input int rep,
                     input logic [31:0] s0, input logic [31:0] d0, input logic [15:0] c0,
                     input logic [31:0] a0, input logic second);
    logic [31:0] es = s0, ed = d0, ea = a0;
    logic [15:0] ec = c0;
    int nacc, n0, wait_n, mm;
    string ctag, mtag, ztag;
    load_mem();
    model(op, esz, dir, rep, es, ed, ec, ea, e_zf, nacc);
    ctag = (rep == 0) ? "R7" : (rep == 1) ? "R8" : "R9";
    if (rep != 0 && c0 == 0) ctag = "R10";
    mtag = (op == 0) ? "R3" : (op == 1) ? "R4" : (op == 4) ? "R5" : "R6";
    ztag = (op == 1) ? "R4" : (op == 4) ? "R5" : "R6";
    n0 = strobes;
    @(negedge clk);
    op_i = 3'(op); esize_i = 2'(esz); dir_i = dir[0]; rep_i = 2'(rep);
    src_i = s0; dst_i = d0; cnt_i = c0; acc_i = a0; start_i = 1'b1;
    @(negedge clk);
    if (second && !done_o) begin
      op_i = 3'd2; rep_i = 2'd0; dst_i = 32'h10; acc_i = 32'hFFFF_FFFF; cnt_i = 16'd7;
      start_i = 1'b1;
    end else start_i = 1'b0;
    wait_n = 0;
    while (!done_o && wait_n < 200) begin
      @(negedge clk); start_i = 1'b0; wait_n++;
    end
    start_i = 1'b0;
    check("R12", "done seen", {31'd0, done_o}, 32'd1);
    check("R2", "src", src_o, es);
    check("R2", "dst", dst_o, ed);
    check(ctag, "count", {16'd0, cnt_o}, {16'd0, ec});
    check(mtag, "acc", acc_o, ea);
    check(ztag, "zf", {31'd0, zf_o}, {31'd0, e_zf});
    check((c0 == 0 && rep != 0) ? "R10" : "R11", "accesses", 32'(strobes - n0), 32'(nacc));
    mm = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mm++;
    check(mtag, "memory mismatches", 32'(mm), 32'd0);
    @(negedge clk);
    check("R12", "done pulse ends", {30'd0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p;
    p = 0;
    for (int i = 0; i < 256; i++) ld_mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    check("R1", "src/dst", src_o | dst_o, 32'd0);
    check("R1", "cnt/acc", acc_o | {16'd0, cnt_o}, 32'd0);
    check("R1", "flags", {27'd0, zf_o, done_o, busy_o, mem_rd_o, mem_wr_o}, 32'd0);
    rst_n = 1'b1;

    for (int op = 0; op < 5; op++)
      for (int esz = 0; esz < 3; esz++)
        for (int dir = 0; dir < 2; dir++)
          for (int rep = 0; rep < 4; rep++)
            for (int vr = 0; vr < 2; vr++) begin
              int n, k;
              logic [31:0] s0, d0, a0, sa, da;
              n = 1 << esz;
              k = (esz + dir + rep) % 3;
              s0 = dir ? 32'h4C : 32'h40;
              d0 = dir ? 32'h8C : 32'h80;
              a0 = 32'hA5C3_0F00 + 32'(p);
              for (int i = 0; i < 256; i++) ld_mem[i] = 8'(i * 37 + p * 11);
              for (int j = 0; j < 3; j++)
                if ((vr == 0) ? (j < k) : (j == k)) begin
                  sa = dir ? s0 - 32'(j * n) : s0 + 32'(j * n);
                  da = dir ? d0 - 32'(j * n) : d0 + 32'(j * n);
                  for (int b = 0; b < n; b++)
                    if (op == 1) ld_mem[da[7:0] + 8'(b)] = ld_mem[sa[7:0] + 8'(b)];
                    else if (op == 4) ld_mem[da[7:0] + 8'(b)] = a0[8*b +: 8];
                end
              run(op, esz, dir, rep, s0, d0, 16'd3, a0, 1'b1);
              p++;
            end

    for (int op = 0; op < 5; op++)
      for (int rep = 1; rep < 4; rep++)
        run(op, 1, 0, rep, 32'h20, 32'hA0, 16'd0, 32'h1234_5678, 1'b0);

    run(0, 2, 1, 1, 32'h5C, 32'hDC, 16'd6, 32'h0, 1'b1);
    run(2, 0, 0, 1, 32'h00, 32'hF8, 16'd12, 32'h0000_00C3, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule